// File: doc/BRIEF.md
# I2C Bit-Level Master Engine

This block drives the wire-level primitives of an I2C master on open-drain clock and data lines. A controller above it hands over one command at a time: bus recovery, START condition, STOP condition, byte write, or byte read that ends with a chosen acknowledge level. The engine reports the acknowledge bit sampled after a write and the data byte assembled from a read. Transaction sequencing, clock stretching, arbitration and target mode are handled elsewhere or not at all.

Every bit is built from four quarter-period slots, and the quarter period comes from a programmable divider on the system clock. Each line is modelled as an output enable: an asserted enable pulls the line low, and a deasserted one leaves the line to its pull-up. The data line comes back as a separate input that passes through a two-flop synchronizer before it is sampled.

Top module: `i2c_phase_master`

## Requirements
- R1: After reset both line enables are low (lines released), busy and done are low, and rsp_data and rsp_nack are zero. While the engine is idle, neither line enable changes.
- R2: Command codes on cmd_op are 1 recovery, 2 START, 3 STOP, 4 write, 5 read. A valid code that is presented with cmd_valid while busy is low is accepted, and busy is high from the next cycle. Codes 0, 6 and 7 are ignored and leave busy low.
- R3: A slot lasts tick_div+1 clock cycles, and tick_div must be at least 1. With S the slot count (4 for START and STOP, 37 for write and read, 40 for recovery), done is a one-cycle pulse S slots after the accepting edge, and busy falls on that same edge.
- R4: START works as follows. Slot 0 is a wait. Slot 1 releases SDA, slot 2 releases SCL, and slot 3 pulls SDA low while SCL stays released.
- R5: STOP works as follows. Slot 0 pulls SCL low, slot 1 pulls SDA low, slot 2 releases SCL, and slot 3 releases SDA while SCL stays released.
- R6: A write sends cmd_wdata MSB first in bit frames 0 to 7, with four slots per frame. In each frame SCL is pulled low in slot 0, SDA takes the bit in slot 1, and SCL is released for slots 2 and 3. SDA never changes while SCL is released, except during START, STOP and recovery.
- R7: In frame 8 of a write the engine releases SDA and samples the synchronized line at the end of slot 2 of that frame. The sampled value appears on rsp_nack with done (1 = NACK, 0 = ACK).
- R8: A read keeps SDA released for frames 0 to 7. Each frame samples the line one slot after SCL is released, and the byte assembled MSB first appears on rsp_data with done.
- R9: In frame 8 of a read, SDA is pulled low when cmd_rd_nack is 0 and released when it is 1, for one full SCL pulse.
- R10: Recovery releases SDA and gives 9 SCL pulses, each 2 slots low and 2 slots released, with SDA released throughout. It then runs a STOP, so SCL is released 10 times in total and both lines end released.
- R11: A command presented while busy is high has no effect on the running command's line activity, duration or result.
- R12: Write and read end with one more slot that pulls SCL low, so SCL is left held low afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_div | input | DIV_W | Slot length minus one, in clock cycles (at least 1) |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code (see R2) |
| cmd_wdata | input | 8 | Byte to send for a write |
| cmd_rd_nack | input | 1 | For a read: 1 releases SDA in the acknowledge bit, 0 pulls it low |
| busy | output | 1 | A command is running |
| done | output | 1 | One-cycle pulse when a command finishes |
| rsp_data | output | 8 | Byte received by the last read |
| rsp_nack | output | 1 | Acknowledge bit sampled by the last write |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| sda_in | input | 1 | Observed SDA line level |

## Verification
Counted from the edge that accepts a command, slot n's line levels are visible from cycle n*(tick_div+1), and done, rsp_data and rsp_nack are valid at cycle S*(tick_div+1). The bench samples every cycle between clock edges at a known offset from acceptance, so each line level and handshake is compared at the exact cycle it is due. The modelled target changes SDA only at frame boundaries. Because of this, the two synchronizer cycles always end before the sampling slot closes, provided tick_div is at least 1. The sweeps run with tick_div of 1 and 3, so that off-by-one errors in slot length are seen.

// File: rtl/i2cpm_pkg.sv
// Shared command codes, slot action record and per-slot action decode.
// Assumes one frame counter wide enough for the recovery command's 10 frames.
package i2cpm_pkg;

    localparam int NUM_BITS       = 8;
    localparam int RECOVER_PULSES = 9;
    localparam int FRAME_W        = $clog2(RECOVER_PULSES + 1) + 1;

    typedef enum logic [2:0] {
        OP_NONE    = 3'd0,
        OP_RECOVER = 3'd1,
        OP_START   = 3'd2,
        OP_STOP    = 3'd3,
        OP_WRITE   = 3'd4,
        OP_READ    = 3'd5
    } op_e;

    // What to do to each line at the start of a slot
    typedef struct packed {
        logic scl_set;
        logic scl_low;
        logic sda_set;
        logic sda_low;
    } act_t;

    function automatic logic op_valid(logic [2:0] c);
        return (c >= 3'd1) && (c <= 3'd5);
    endfunction

    // Four-slot stop condition
    function automatic act_t stop_act(logic [1:0] q);
        act_t a = '0;
        case (q)
            2'd0: begin a.scl_set = 1'b1; a.scl_low = 1'b1; end
            2'd1: begin a.sda_set = 1'b1; a.sda_low = 1'b1; end
            2'd2: a.scl_set = 1'b1;
            default: a.sda_set = 1'b1;
        endcase
        return a;
    endfunction

    // Action for slot q of frame f of command op; dlow is the data level
    function automatic act_t slot_act(op_e op, logic [FRAME_W-1:0] f,
                                      logic [1:0] q, logic dlow);
        act_t a = '0;
        case (op)
            OP_START: begin
                case (q)
                    2'd1: a.sda_set = 1'b1;
                    2'd2: a.scl_set = 1'b1;
                    2'd3: begin a.sda_set = 1'b1; a.sda_low = 1'b1; end
                    default: ;
                endcase
            end
            OP_STOP: a = stop_act(q);
            OP_RECOVER: begin
                if (f == FRAME_W'(RECOVER_PULSES)) a = stop_act(q);
                else if (q == 2'd0) begin
                    a.scl_set = 1'b1; a.scl_low = 1'b1; a.sda_set = 1'b1;
                end else if (q == 2'd2) a.scl_set = 1'b1;
            end
            OP_WRITE, OP_READ: begin
                if (f == FRAME_W'(NUM_BITS + 1)) begin
                    if (q == 2'd0) begin a.scl_set = 1'b1; a.scl_low = 1'b1; end
                end else begin
                    case (q)
                        2'd0: begin a.scl_set = 1'b1; a.scl_low = 1'b1; end
                        2'd1: begin a.sda_set = 1'b1; a.sda_low = dlow; end
                        2'd2: a.scl_set = 1'b1;
                        default: ;
                    endcase
                end
            end
            default: ;
        endcase
        return a;
    endfunction

endpackage

// File: rtl/i2cpm_qtick.sv
// Quarter-period tick divider. Counts while run is high and pulses tick
// every div+1 cycles; held at zero while idle so each command starts a
// fresh slot.
module i2cpm_qtick #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] cnt_q;

    assign tick = run && (cnt_q == div);

    // Slot counter: clears when idle or at the end of a slot
    always_ff @(posedge clk) begin
        if (!rst_n || !run || tick) cnt_q <= '0;
        else                        cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/i2cpm_sync2.sv
// Two-flop synchronizer for the returning data line. Resets to the
// released (high) level.
module i2cpm_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic meta_q;

    // Two-stage capture of the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b1;
            dout   <= 1'b1;
        end else begin
            meta_q <= din;
            dout   <= meta_q;
        end
    end
endmodule

// File: rtl/i2cpm_seq.sv
// Slot sequencer: walks frame/quarter counters for the running command,
// applies each slot's line action at the slot start and collects the
// sampled data line. Assumes a tick at most once per slot boundary.
module i2cpm_seq
    import i2cpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                sda_s,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [NUM_BITS-1:0] cmd_wdata,
    input  logic                cmd_rd_nack,
    output logic                busy,
    output logic                done,
    output logic [NUM_BITS-1:0] rsp_data,
    output logic                rsp_nack,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic [2:0]          cur_op
);
    op_e                  op_q;
    logic [FRAME_W-1:0]   frame_q, nxt_f;
    logic [1:0]           qtr_q, nxt_q;
    logic [NUM_BITS-1:0]  wdat_q;
    logic                 nack_q;
    logic [NUM_BITS:0]    samp_q;
    logic                 last_slot, dlow, accept, sample_now, byte_op;
    act_t                 first_a, step_a;

    assign cur_op  = op_q;
    assign byte_op = (op_q == OP_WRITE) || (op_q == OP_READ);
    assign accept  = cmd_valid && !busy && op_valid(cmd_op);
    assign nxt_q   = qtr_q + 2'd1;
    assign nxt_f   = (qtr_q == 2'd3) ? frame_q + FRAME_W'(1) : frame_q;
    assign sample_now = byte_op && (qtr_q == 2'd2)
                        && (frame_q <= FRAME_W'(NUM_BITS));

    // Final slot of each command
    always_comb begin
        case (op_q)
            OP_START, OP_STOP: last_slot = (frame_q == '0) && (qtr_q == 2'd3);
            OP_RECOVER: last_slot = (frame_q == FRAME_W'(RECOVER_PULSES))
                                    && (qtr_q == 2'd3);
            default: last_slot = (frame_q == FRAME_W'(NUM_BITS + 1))
                                 && (qtr_q == 2'd0);
        endcase
    end

    // Data level for the next frame: payload bit, released, or ack level
    always_comb begin
        if (nxt_f < FRAME_W'(NUM_BITS))
            dlow = (op_q == OP_WRITE) ? ~wdat_q[NUM_BITS-1] : 1'b0;
        else
            dlow = (op_q == OP_READ) ? ~nack_q : 1'b0;
    end

    assign first_a = slot_act(op_e'(cmd_op), '0, 2'd0, 1'b0);
    assign step_a  = slot_act(op_q, nxt_f, nxt_q, dlow);

    // Command acceptance, slot stepping, line actions and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy     <= 1'b0;
            done     <= 1'b0;
            op_q     <= OP_NONE;
            frame_q  <= '0;
            qtr_q    <= '0;
            wdat_q   <= '0;
            nack_q   <= 1'b0;
            samp_q   <= '0;
            rsp_data <= '0;
            rsp_nack <= 1'b0;
            scl_oe   <= 1'b0;
            sda_oe   <= 1'b0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy    <= 1'b1;
                op_q    <= op_e'(cmd_op);
                wdat_q  <= cmd_wdata;
                nack_q  <= cmd_rd_nack;
                frame_q <= '0;
                qtr_q   <= '0;
                if (first_a.scl_set) scl_oe <= first_a.scl_low;
                if (first_a.sda_set) sda_oe <= first_a.sda_low;
            end else if (busy && tick) begin
                if (sample_now) samp_q <= {samp_q[NUM_BITS-1:0], sda_s};
                if (last_slot) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                    if (op_q == OP_READ)  rsp_data <= samp_q[NUM_BITS:1];
                    if (op_q == OP_WRITE) rsp_nack <= samp_q[0];
                end else begin
                    frame_q <= nxt_f;
                    qtr_q   <= nxt_q;
                    if (step_a.scl_set) scl_oe <= step_a.scl_low;
                    if (step_a.sda_set) sda_oe <= step_a.sda_low;
                    if (nxt_q == 2'd1 && nxt_f < FRAME_W'(NUM_BITS))
                        wdat_q <= wdat_q << 1;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_phase_master.sv
// Top of the bit-level I2C master: quarter-period divider, data-line
// synchronizer and slot sequencer. Assumes tick_div >= 1 and changes to
// tick_div only while idle.
module i2c_phase_master
    import i2cpm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DIV_W-1:0]    tick_div,
    input  logic                cmd_valid,
    input  logic [2:0]          cmd_op,
    input  logic [NUM_BITS-1:0] cmd_wdata,
    input  logic                cmd_rd_nack,
    output logic                busy,
    output logic                done,
    output logic [NUM_BITS-1:0] rsp_data,
    output logic                rsp_nack,
    output logic                scl_oe,
    output logic                sda_oe,
    input  logic                sda_in
);
    logic       tick;
    logic       sda_s;
    logic [2:0] cur_op;

    i2cpm_qtick #(.DIV_W(DIV_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(busy), .div(tick_div), .tick(tick)
    );

    i2cpm_sync2 u_sync (
        .clk(clk), .rst_n(rst_n), .din(sda_in), .dout(sda_s)
    );

    i2cpm_seq u_seq (
        .clk(clk), .rst_n(rst_n), .tick(tick), .sda_s(sda_s),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_wdata(cmd_wdata),
        .cmd_rd_nack(cmd_rd_nack), .busy(busy), .done(done),
        .rsp_data(rsp_data), .rsp_nack(rsp_nack), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .cur_op(cur_op)
    );
endmodule

// File: rtl/i2cpm_chk.sv
// Protocol checker bound to the engine top; observes ports and the
// running command code only.
module i2cpm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_valid,
    input logic [2:0] cmd_op,
    input logic       busy,
    input logic       done,
    input logic       scl_oe,
    input logic       sda_oe,
    input logic [2:0] cur_op
);
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && cmd_op >= 3'd1 && cmd_op <= 3'd5) |=> busy);

    // R2
    bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy && (cmd_op == 3'd0 || cmd_op > 3'd5)) |=> !busy);

    // R3
    done_fell_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $fell(busy));

    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy)) |-> ($stable(scl_oe) && $stable(sda_oe)));

    // R6
    sda_scl_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_oe && !$past(scl_oe) && !$stable(sda_oe))
        |-> (cur_op == 3'd1 || cur_op == 3'd2 || cur_op == 3'd3));

    // R11
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cmd_valid) |=> $stable(cur_op));
endmodule

bind i2c_phase_master i2cpm_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .busy(busy), .done(done), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .cur_op(cur_op)
);

// File: tb/test_i2c_phase_master.sv
`timescale 1ns/1ps
module test_i2c_phase_master;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] tick_div = 8'd1;
    logic       cmd_valid = 1'b0;
    logic [2:0] cmd_op = 3'd0;
    logic [7:0] cmd_wdata = 8'd0;
    logic       cmd_rd_nack = 1'b0;
    logic       busy, done, rsp_nack, scl_oe, sda_oe, sda_in;
    logic [7:0] rsp_data;

    int  n_checks = 0;
    int  n_errors = 0;
    int  t_now = 0;
    int  qlen = 2;
    bit  slv_on = 0;
    bit  slv_rd = 0;
    bit  [7:0] slv_byte = 8'd0;
    bit  slv_nack = 0;
    logic slv_rel;
    logic exp_scl = 1'b0;
    logic exp_sda = 1'b0;

    always #4 clk = ~clk;

    i2c_phase_master #(.DIV_W(8)) i_i2c_phase_master (
        .clk(clk), .rst_n(rst_n), .tick_div(tick_div), .cmd_valid(cmd_valid),
        .cmd_op(cmd_op), .cmd_wdata(cmd_wdata), .cmd_rd_nack(cmd_rd_nack),
        .busy(busy), .done(done), .rsp_data(rsp_data), .rsp_nack(rsp_nack),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
    );

    // Modelled target: changes its drive only at frame boundaries
    always_comb begin
        int fr;
        fr = t_now / (4 * qlen);
        slv_rel = 1'b1;
        if (slv_on) begin
            if (fr < 8) slv_rel = slv_rd ? slv_byte[7 - fr] : 1'b1;
            else if (fr == 8) slv_rel = slv_rd ? 1'b1 : slv_nack;
        end
    end
    assign sda_in = ~sda_oe & slv_rel;

    task automatic check(bit ok, string req, int act, int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected action {scl_set, scl_low, sda_set, sda_low} per the requirements
    function automatic logic [3:0] exp_act(int op, int f, int q,
                                           bit [7:0] w, bit nk);
        logic [3:0] stp [4] = '{4'b1100, 4'b0011, 4'b1000, 4'b0010};
        if (op == 2) begin
            if (q == 1) return 4'b0010;
            if (q == 2) return 4'b1000;
            if (q == 3) return 4'b0011;
            return 4'b0000;
        end
        if (op == 3 || (op == 1 && f == 9)) return stp[q];
        if (op == 1) begin
            if (q == 0) return 4'b1110;
            if (q == 2) return 4'b1000;
            return 4'b0000;
        end
        if (f == 9) return (q == 0) ? 4'b1100 : 4'b0000;
        if (q == 0) return 4'b1100;
        if (q == 2) return 4'b1000;
        if (q == 1) begin
            if (f < 8) return {3'b001, (op == 4) ? ~w[7 - f] : 1'b0};
            return {3'b001, (op == 5) ? ~nk : 1'b0};
        end
        return 4'b0000;
    endfunction

    task automatic run_cmd(int op, bit [7:0] w, bit nk, bit [7:0] sb,
                           bit sn, bit inject);
        int nslots, line_bad, tim_bad, rises;
        logic prev_scl;
        string lreq;
        nslots = (op == 1) ? 40 : (op == 2 || op == 3) ? 4 : 37;
        line_bad = 0; tim_bad = 0; rises = 0;
        slv_on = (op == 4 || op == 5); slv_rd = (op == 5);
        slv_byte = sb; slv_nack = sn; t_now = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op); cmd_wdata = w; cmd_rd_nack = nk;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0; cmd_wdata = ~w; cmd_rd_nack = ~nk;
        prev_scl = exp_scl;
        for (int t = 0; t <= nslots * qlen; t++) begin
            t_now = t;
            if (t < nslots * qlen && t % qlen == 0) begin
                logic [3:0] a;
                int n;
                n = t / qlen;
                a = exp_act(op, n / 4, n % 4, w, nk);
                if (a[3]) exp_scl = a[2];
                if (a[1]) exp_sda = a[0];
            end
            if (scl_oe !== exp_scl || sda_oe !== exp_sda) line_bad++;
            if (prev_scl === 1'b1 && scl_oe === 1'b0) rises++;
            prev_scl = scl_oe;
            if (t < nslots * qlen) begin
                if (busy !== 1'b1 || done !== 1'b0) tim_bad++;
            end else begin
                if (busy !== 1'b0 || done !== 1'b1) tim_bad++;
            end
            if (inject && t == 5) begin cmd_valid = 1'b1; cmd_op = 3'd3; end
            if (inject && t == 6) cmd_valid = 1'b0;
            if (t == nslots * qlen) begin
                if (op == 4) check(rsp_nack === sn, "R7 ack sample", rsp_nack, sn);
                if (op == 5) check(rsp_data === sb, "R8 read data", rsp_data, sb);
            end
            @(negedge clk);
        end
        slv_on = 0;
        tim_bad += (done !== 1'b0);
        case (op)
            1: lreq = "R10 recovery lines";
            2: lreq = "R4 start lines";
            3: lreq = "R5 stop lines";
            4: lreq = "R6 R12 write lines";
            default: lreq = "R9 R12 read lines";
        endcase
        if (inject) lreq = {"R11 ", lreq};
        check(line_bad == 0, lreq, line_bad, 0);
        check(tim_bad == 0, inject ? "R11 R3 busy/done timing" : "R3 busy/done timing",
              tim_bad, 0);
        if (op == 1) begin
            check(rises == 10, "R10 scl release count", rises, 10);
            check(scl_oe === 1'b0 && sda_oe === 1'b0, "R10 lines released at end",
                  {scl_oe, sda_oe}, 0);
        end
    endtask

    task automatic bad_op(int op);
        int bad = 0;
        logic s0, d0;
        s0 = scl_oe; d0 = sda_oe;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'(op);
        @(negedge clk);
        cmd_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            if (busy !== 1'b0 || done !== 1'b0 || scl_oe !== s0 || sda_oe !== d0) bad++;
            @(negedge clk);
        end
        check(bad == 0, "R2 invalid code ignored", bad, 0);
    endtask

    // Watchdog: a hung run is reported as a failed check
    initial begin
        repeat (190000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(scl_oe === 1'b0 && sda_oe === 1'b0, "R1 lines released", {scl_oe, sda_oe}, 0);
        check(busy === 1'b0 && done === 1'b0, "R1 busy/done low", {busy, done}, 0);
        check(rsp_data === 8'd0 && rsp_nack === 1'b0, "R1 results zero",
              {rsp_nack, rsp_data}, 0);

        qlen = 2; tick_div = 8'd1;
        bad_op(0); bad_op(6); bad_op(7);
        run_cmd(1, 8'h00, 0, 8'h00, 0, 0);
        run_cmd(2, 8'h00, 0, 8'h00, 0, 0);
        for (int i = 0; i < 256; i++)
            run_cmd(4, 8'(i), 0, 8'h00, i[1], 0);
        run_cmd(3, 8'h00, 0, 8'h00, 0, 0);
        run_cmd(2, 8'h00, 0, 8'h00, 0, 0);
        for (int i = 0; i < 256; i++)
            run_cmd(5, 8'h00, i[0], 8'(i) ^ 8'h5A, 0, 0);
        run_cmd(4, 8'hC3, 0, 8'h00, 1, 1);
        run_cmd(5, 8'h00, 1, 8'h96, 0, 1);
        run_cmd(3, 8'h00, 0, 8'h00, 0, 0);

        qlen = 4; tick_div = 8'd3;
        bad_op(6);
        run_cmd(1, 8'h00, 0, 8'h00, 0, 0);
        run_cmd(2, 8'h00, 0, 8'h00, 0, 0);
        run_cmd(4, 8'hA5, 0, 8'h00, 0, 0);
        run_cmd(4, 8'h01, 0, 8'h00, 1, 0);
        run_cmd(5, 8'h00, 0, 8'h81, 0, 0);
        run_cmd(5, 8'h00, 1, 8'h7E, 0, 1);
        run_cmd(3, 8'h00, 0, 8'h00, 0, 0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule